// File: doc/BRIEF.md
# Control Register Write Validator

This block holds a small file of five processor control registers and arbitrates every move into or out of them. A request carries a 3-bit register selector plus one extension bit, the current privilege level, a long-mode flag and the write data. In the cycle after a request, the block returns one response. That response is either read data, a general-protection fault, an invalid-opcode fault, or a completed write. A completed write can also raise one-cycle side-effect pulses that a translation cache and a page-walker front end consume.

Each write is screened before it lands. The checks cover privilege, illegal bit pairs in the main mode register, and reserved bits in the feature register and the priority register. Reserved bits in the mode register and the table-base register are cleared silently, and the cache-type bit of the mode register is always forced to 1. A small response state machine records the outcome of the sampled request. It has five states: IDLE, READ, WRITE, GP and UD. On every clock edge, the machine moves from its current state to the state chosen by the request sampled at that edge:

- No request leads to IDLE.
- A privilege violation leads to GP.
- An unknown selector leads to UD.
- A read leads to READ.
- A write that breaks a rule leads to GP.
- Any other write leads to WRITE.

Register slots and their selector index (index = {ext, sel} in long mode, {0, sel} otherwise): MODE=0, FAULTADDR=2, TBASE=3, FEAT=4, PRIO=8.

Top module: `ctl_write_validator`

## Requirements
- R1: A request with `cpl` not 0 gives `fault_gp`=1 and leaves every register unchanged.
- R2: An index outside {0,2,3,4,8} gives `fault_ud`=1. Outside long mode `req_ext` is ignored, so index 8 cannot be reached there.
- R3: A MODE write with bit 31 (paging) set and bit 0 (protection) clear, or with bit 29 (no-writethrough) set and bit 30 (cache-disable) clear, gives `fault_gp`=1 and no update.
- R4: A FEAT write with any bit set outside bits [10:0] and bit 13, or a PRIO write with any bit set above bit 3, gives `fault_gp`=1 and no update.
- R5: MODE keeps only bits 0-5, 16, 18 and 29-31, and bit 4 always reads 1. TBASE keeps only bits 3, 4 and [PHYS_W-1:12]. The remaining bits are dropped without a fault.
- R6: Every accepted TBASE write pulses `flush_local` for one cycle.
- R7: An accepted write that changes MODE bit 0 or bit 31, or FEAT bit 4, 5 or 7, pulses `flush_all`.
- R8: `ptr_reload` pulses in three cases: a FEAT write that sets bit 5 while MODE bit 31 is 1; a TBASE write while FEAT bit 5 and MODE bit 31 are both 1; or a MODE write that sets bit 31 while FEAT bit 5 is 1.
- R9: In long mode, a FEAT write with bit 5 clear gives `fault_gp`=1.
- R10: Outside long mode, the upper half of the write data is discarded, and read data returns the low half zero-extended.
- R11: Each request gets exactly one response one cycle later (`rsp_valid`=1). At most one fault flag is set, and a faulting response carries no pulse and zero read data.
- R12: After reset, MODE reads 0x10, all other registers read 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 3 | Register selector |
| req_ext | input | 1 | Selector extension bit (long mode only) |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 64-bit operation mode |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W | Read data (0 unless READ) |
| fault_gp | output | 1 | General-protection fault |
| fault_ud | output | 1 | Invalid-opcode fault |
| flush_local | output | 1 | Flush non-global translations |
| flush_all | output | 1 | Flush all translations |
| ptr_reload | output | 1 | Reload the pointer table |

## Verification
A register that took a faulting write, or lost its masking, shows up at the first read of that slot, one cycle after the read request. A wrong stored value of MODE bit 31 or FEAT bit 5 also shows earlier, as a missing or extra `ptr_reload` or `flush_all` on the next write that depends on it. A response state that strays shows within one cycle as a wrong `rsp_valid` or fault flag. Long runs of mixed random requests between readbacks therefore leave a corrupted register visible within a handful of requests.

// File: rtl/ctlv_pkg.sv
`timescale 1ns/1ps
package ctlv_pkg;

    localparam int NUM_SLOTS = 5;

    typedef enum logic [2:0] {
        SLOT_MODE  = 3'd0,
        SLOT_FADDR = 3'd1,
        SLOT_TBASE = 3'd2,
        SLOT_FEAT  = 3'd3,
        SLOT_PRIO  = 3'd4
    } slot_e;

    typedef enum logic [2:0] {
        RSP_IDLE  = 3'd0,
        RSP_READ  = 3'd1,
        RSP_WRITE = 3'd2,
        RSP_GP    = 3'd3,
        RSP_UD    = 3'd4
    } rsp_state_e;

    // MODE register bit positions
    localparam int M_PROT  = 0;
    localparam int M_CTYPE = 4;
    localparam int M_NWT   = 29;
    localparam int M_CDIS  = 30;
    localparam int M_PAGE  = 31;

    // FEAT register bit positions
    localparam int F_BIGPG = 4;
    localparam int F_WIDE  = 5;
    localparam int F_GLOB  = 7;

endpackage

// File: rtl/ctlv_decode.sv
`timescale 1ns/1ps
module ctlv_decode
    import ctlv_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       ext,
    input  logic       long_mode,
    output slot_e      slot,
    output logic       slot_ok
);

    logic [3:0] index;

    assign index = long_mode ? {ext, sel} : {1'b0, sel};

    always_comb begin
        slot    = SLOT_MODE;
        slot_ok = 1'b1;
        unique case (index)
            4'd0:    slot = SLOT_MODE;
            4'd2:    slot = SLOT_FADDR;
            4'd3:    slot = SLOT_TBASE;
            4'd4:    slot = SLOT_FEAT;
            4'd8:    slot = SLOT_PRIO;
            default: slot_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/ctlv_rules.sv
`timescale 1ns/1ps
module ctlv_rules
    import ctlv_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PHYS_W = 40
) (
    input  slot_e             slot,
    input  logic [DATA_W-1:0] wd,
    input  logic              long_mode,
    output logic              rule_fault,
    output logic [DATA_W-1:0] store_val
);

    localparam logic [DATA_W-1:0] ONES      = '1;
    localparam logic [DATA_W-1:0] MODE_KEEP = DATA_W'(64'h0000_0000_E005_003F);
    localparam logic [DATA_W-1:0] TB_KEEP   = ((ONES << 12) & ~(ONES << PHYS_W))
                                              | DATA_W'(64'h18);
    localparam logic [DATA_W-1:0] FEAT_OK   = DATA_W'(64'h27FF);
    localparam logic [DATA_W-1:0] PRIO_OK   = DATA_W'(64'hF);
    localparam logic [DATA_W-1:0] CTYPE_ON  = DATA_W'(1) << M_CTYPE;

    always_comb begin
        rule_fault = 1'b0;
        store_val  = wd;
        unique case (slot)
            SLOT_MODE: begin
                rule_fault = (wd[M_PAGE] & ~wd[M_PROT]) | (wd[M_NWT] & ~wd[M_CDIS]);
                store_val  = (wd & MODE_KEEP) | CTYPE_ON;
            end
            SLOT_FADDR: store_val = wd;
            SLOT_TBASE: store_val = wd & TB_KEEP;
            SLOT_FEAT: begin
                rule_fault = (|(wd & ~FEAT_OK)) | (long_mode & ~wd[F_WIDE]);
            end
            SLOT_PRIO: rule_fault = |(wd & ~PRIO_OK);
            default: begin
                rule_fault = 1'b1;
                store_val  = '0;
            end
        endcase
    end

endmodule

// File: rtl/ctlv_effects.sv
`timescale 1ns/1ps
module ctlv_effects
    import ctlv_pkg::*;
(
    input  slot_e slot,
    input  logic  old_prot,
    input  logic  old_page,
    input  logic  old_bigpg,
    input  logic  old_wide,
    input  logic  old_glob,
    input  logic  new_prot,
    input  logic  new_page,
    input  logic  new_bigpg,
    input  logic  new_wide,
    input  logic  new_glob,
    output logic  want_local,
    output logic  want_all,
    output logic  want_reload
);

    always_comb begin
        want_local  = 1'b0;
        want_all    = 1'b0;
        want_reload = 1'b0;
        unique case (slot)
            SLOT_MODE: begin
                want_all    = (old_prot ^ new_prot) | (old_page ^ new_page);
                want_reload = new_page & ~old_page & old_wide;
            end
            SLOT_TBASE: begin
                want_local  = 1'b1;
                want_reload = old_wide & old_page;
            end
            SLOT_FEAT: begin
                want_all    = (old_bigpg ^ new_bigpg) | (old_wide ^ new_wide)
                              | (old_glob ^ new_glob);
                want_reload = new_wide & ~old_wide & old_page;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctlv_regfile.sv
`timescale 1ns/1ps
module ctlv_regfile
    import ctlv_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  slot_e                             slot,
    input  logic [DATA_W-1:0]                 wval,
    output logic [NUM_SLOTS-1:0][DATA_W-1:0]  regs_q
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [DATA_W-1:0] RST_V = (g == 0) ? (DATA_W'(1) << M_CTYPE) : '0;
        logic [DATA_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= RST_V;
            end else if (we && (slot == slot_e'(g))) begin
                slot_q <= wval;
            end
        end

        assign regs_q[g] = slot_q;
    end

endmodule

// File: rtl/ctl_write_validator.sv
`timescale 1ns/1ps
module ctl_write_validator
    import ctlv_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int PHYS_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_sel,
    input  logic              req_ext,
    input  logic [1:0]        cpl,
    input  logic              long_mode,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              fault_gp,
    output logic              fault_ud,
    output logic              flush_local,
    output logic              flush_all,
    output logic              ptr_reload
);

    localparam int HALF_W = DATA_W / 2;

    rsp_state_e state_q, state_d;
    slot_e      slot;
    logic       slot_ok;
    logic       rule_fault;
    logic [DATA_W-1:0] wd, store_val, cur_val, rd_val;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] regs_q;
    logic       want_local, want_all, want_reload;
    logic       we;
    logic [DATA_W-1:0] rdata_q;
    logic       local_q, all_q, reload_q;

    // Narrow operand outside long mode
    assign wd = long_mode ? req_wdata : {{HALF_W{1'b0}}, req_wdata[HALF_W-1:0]};

    ctlv_decode u_decode (
        .sel       (req_sel),
        .ext       (req_ext),
        .long_mode (long_mode),
        .slot      (slot),
        .slot_ok   (slot_ok)
    );

    ctlv_rules #(.DATA_W(DATA_W), .PHYS_W(PHYS_W)) u_rules (
        .slot       (slot),
        .wd         (wd),
        .long_mode  (long_mode),
        .rule_fault (rule_fault),
        .store_val  (store_val)
    );

    ctlv_effects u_effects (
        .slot        (slot),
        .old_prot    (regs_q[0][M_PROT]),
        .old_page    (regs_q[0][M_PAGE]),
        .old_bigpg   (regs_q[3][F_BIGPG]),
        .old_wide    (regs_q[3][F_WIDE]),
        .old_glob    (regs_q[3][F_GLOB]),
        .new_prot    (store_val[M_PROT]),
        .new_page    (store_val[M_PAGE]),
        .new_bigpg   (store_val[F_BIGPG]),
        .new_wide    (store_val[F_WIDE]),
        .new_glob    (store_val[F_GLOB]),
        .want_local  (want_local),
        .want_all    (want_all),
        .want_reload (want_reload)
    );

    ctlv_regfile #(.DATA_W(DATA_W)) u_regfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (we),
        .slot   (slot),
        .wval   (store_val),
        .regs_q (regs_q)
    );

    // Read path selection
    always_comb begin
        unique case (slot)
            SLOT_MODE:  cur_val = regs_q[0];
            SLOT_FADDR: cur_val = regs_q[1];
            SLOT_TBASE: cur_val = regs_q[2];
            SLOT_FEAT:  cur_val = regs_q[3];
            SLOT_PRIO:  cur_val = regs_q[4];
            default:    cur_val = '0;
        endcase
    end

    assign rd_val = long_mode ? cur_val : {{HALF_W{1'b0}}, cur_val[HALF_W-1:0]};

    // Next response state from the sampled request
    always_comb begin
        state_d = RSP_IDLE;
        if (req_valid) begin
            if (cpl != 2'd0) begin
                state_d = RSP_GP;
            end else if (!slot_ok) begin
                state_d = RSP_UD;
            end else if (!req_write) begin
                state_d = RSP_READ;
            end else if (rule_fault) begin
                state_d = RSP_GP;
            end else begin
                state_d = RSP_WRITE;
            end
        end
    end

    assign we = (state_d == RSP_WRITE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Response payload registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            local_q  <= 1'b0;
            all_q    <= 1'b0;
            reload_q <= 1'b0;
        end else begin
            rdata_q  <= (state_d == RSP_READ) ? rd_val : '0;
            local_q  <= we & want_local;
            all_q    <= we & want_all;
            reload_q <= we & want_reload;
        end
    end

    // Outputs decoded from the response state
    always_comb begin
        rsp_valid   = 1'b0;
        rsp_rdata   = '0;
        fault_gp    = 1'b0;
        fault_ud    = 1'b0;
        flush_local = 1'b0;
        flush_all   = 1'b0;
        ptr_reload  = 1'b0;
        unique case (state_q)
            RSP_IDLE: ;
            RSP_READ: begin
                rsp_valid = 1'b1;
                rsp_rdata = rdata_q;
            end
            RSP_WRITE: begin
                rsp_valid   = 1'b1;
                flush_local = local_q;
                flush_all   = all_q;
                ptr_reload  = reload_q;
            end
            RSP_GP: begin
                rsp_valid = 1'b1;
                fault_gp  = 1'b1;
            end
            RSP_UD: begin
                rsp_valid = 1'b1;
                fault_ud  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ctlv_checker.sv
`timescale 1ns/1ps
module ctlv_checker #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [2:0]        req_sel,
    input logic              req_ext,
    input logic [1:0]        cpl,
    input logic              long_mode,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              fault_gp,
    input logic              fault_ud,
    input logic              flush_local,
    input logic              flush_all,
    input logic              ptr_reload
);

    localparam logic [DATA_W-1:0] FEAT_OK = DATA_W'(64'h27FF);

    logic priv0;
    assign priv0 = (cpl == 2'd0);

    p_priv_gp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv0) |=> fault_gp);

    p_pair_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && priv0 && req_sel == 3'd0 && !req_ext
         && req_wdata[31] && !req_wdata[0]) |=> fault_gp);

    p_feat_rsv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && priv0 && long_mode && req_sel == 3'd4 && !req_ext
         && |(req_wdata & ~FEAT_OK)) |=> fault_gp);

    p_ctype_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && priv0 && req_sel == 3'd0 && !req_ext) |=> rsp_rdata[4]);

    p_local_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && priv0 && req_sel == 3'd3 && !req_ext) |=> flush_local);

    p_wide_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && priv0 && long_mode && req_sel == 3'd4 && !req_ext
         && !req_wdata[5]) |=> fault_gp);

    p_narrow_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !long_mode) |=> (rsp_rdata[DATA_W-1:DATA_W/2] == '0));

    p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !flush_local && !flush_all && !ptr_reload));

    p_fault_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_gp && fault_ud));

    p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_gp || fault_ud) |-> (!flush_local && !flush_all && !ptr_reload
                                    && rsp_rdata == '0));

endmodule

bind ctl_write_validator ctlv_checker #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_ctl_write_validator.sv
`timescale 1ns/1ps
module test_ctl_write_validator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_sel = '0;
    logic        req_ext = 1'b0;
    logic [1:0]  cpl = '0;
    logic        long_mode = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        fault_gp, fault_ud, flush_local, flush_all, ptr_reload;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model state and expected response
    logic [63:0] mdl [5];
    logic [63:0] e_rd;
    bit e_gp, e_ud, e_fl, e_fa, e_pr;
    string m_tag;

    localparam logic [63:0] MODE_KEEP = 64'h0000_0000_E005_003F;
    localparam logic [63:0] TB_KEEP   = 64'h0000_00FF_FFFF_F018;

    always #2.5 clk = ~clk;

    ctl_write_validator i_ctl_write_validator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_ext(req_ext), .cpl(cpl), .long_mode(long_mode),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .fault_gp(fault_gp), .fault_ud(fault_ud), .flush_local(flush_local),
        .flush_all(flush_all), .ptr_reload(ptr_reload)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int slot_of(input bit [3:0] idx);
        case (idx)
            4'd0: return 0;
            4'd2: return 1;
            4'd3: return 2;
            4'd4: return 3;
            4'd8: return 4;
            default: return -1;
        endcase
    endfunction

    // Reference model: computes expected response and updates mdl
    task automatic model(input bit w, input bit [2:0] sel, input bit ext,
                         input bit [1:0] cp, input bit lm, input logic [63:0] d);
        int k;
        logic [63:0] wdv, nv;
        bit bad;
        k = slot_of(lm ? {ext, sel} : {1'b0, sel});
        wdv = lm ? d : {32'h0, d[31:0]};
        e_rd = '0; e_gp = 0; e_ud = 0; e_fl = 0; e_fa = 0; e_pr = 0;
        bad = 0; nv = wdv;
        if (cp != 2'd0) begin
            e_gp = 1; m_tag = "R1";
        end else if (k < 0) begin
            e_ud = 1; m_tag = "R2";
        end else if (!w) begin
            e_rd = lm ? mdl[k] : {32'h0, mdl[k][31:0]};
            m_tag = lm ? "R11" : "R10";
        end else begin
            case (k)
                0: begin
                    bad = (wdv[31] && !wdv[0]) || (wdv[29] && !wdv[30]);
                    nv = (wdv & MODE_KEEP) | 64'h10;
                    m_tag = bad ? "R3" : "R5_R7";
                    e_fa = (nv[0] != mdl[0][0]) || (nv[31] != mdl[0][31]);
                    e_pr = nv[31] && !mdl[0][31] && mdl[3][5];
                end
                1: m_tag = "R10";
                2: begin
                    nv = wdv & TB_KEEP;
                    m_tag = "R6_R8";
                    e_fl = 1;
                    e_pr = mdl[3][5] && mdl[0][31];
                end
                3: begin
                    bad = ((wdv & ~64'h27FF) != 0) || (lm && !wdv[5]);
                    m_tag = bad ? (((wdv & ~64'h27FF) != 0) ? "R4" : "R9") : "R7_R8";
                    e_fa = (nv[4] != mdl[3][4]) || (nv[5] != mdl[3][5]) || (nv[7] != mdl[3][7]);
                    e_pr = nv[5] && !mdl[3][5] && mdl[0][31];
                end
                default: begin
                    bad = (wdv & ~64'hF) != 0;
                    m_tag = "R4";
                end
            endcase
            if (bad) begin
                e_gp = 1; e_fa = 0; e_pr = 0; e_fl = 0;
            end else begin
                mdl[k] = nv;
            end
        end
    endtask

    task automatic acc(input bit w, input bit [2:0] sel, input bit ext,
                       input bit [1:0] cp, input bit lm, input logic [63:0] d,
                       input string tg);
        string t;
        model(w, sel, ext, cp, lm, d);
        t = (tg == "") ? m_tag : tg;
        req_valid = 1; req_write = w; req_sel = sel; req_ext = ext;
        cpl = cp; long_mode = lm; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 1'b1, "R11", "rsp_valid", 64'(rsp_valid), 64'd1);
        chk(rsp_rdata == e_rd, t, "rdata", rsp_rdata, e_rd);
        chk(fault_gp == e_gp, t, "fault_gp", 64'(fault_gp), 64'(e_gp));
        chk(fault_ud == e_ud, t, "fault_ud", 64'(fault_ud), 64'(e_ud));
        chk(flush_local == e_fl, t, "flush_local", 64'(flush_local), 64'(e_fl));
        chk(flush_all == e_fa, t, "flush_all", 64'(flush_all), 64'(e_fa));
        chk(ptr_reload == e_pr, t, "ptr_reload", 64'(ptr_reload), 64'(e_pr));
    endtask

    task automatic rd(input bit [2:0] sel, input bit ext, input string tg);
        acc(1'b0, sel, ext, 2'd0, 1'b1, 64'h0, tg);
    endtask

    task automatic wr(input bit [2:0] sel, input bit ext, input bit lm,
                      input logic [63:0] d, input string tg);
        acc(1'b1, sel, ext, 2'd0, lm, d, tg);
    endtask

    initial begin
        #(5 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        mdl[0] = 64'h10; mdl[1] = 0; mdl[2] = 0; mdl[3] = 0; mdl[4] = 0;
        void'($urandom(32'd7731));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R12: reset state
        chk(rsp_valid == 0 && fault_gp == 0 && fault_ud == 0 && flush_all == 0,
            "R12", "idle outputs", {60'h0, rsp_valid, fault_gp, fault_ud, flush_all}, 64'h0);
        rd(3'd0, 1'b0, "R12");
        rd(3'd2, 1'b0, "R12");
        rd(3'd3, 1'b0, "R12");
        rd(3'd4, 1'b0, "R12");
        rd(3'd0, 1'b1, "R12");

        // R1: privilege fault, no update
        acc(1'b1, 3'd2, 1'b0, 2'd3, 1'b1, 64'h1234_5678_9ABC_DEF0, "R1");
        acc(1'b0, 3'd2, 1'b0, 2'd1, 1'b1, 64'h0, "R1");
        rd(3'd2, 1'b0, "R1");

        // R2: unknown selectors, ext ignored outside long mode
        acc(1'b0, 3'd1, 1'b0, 2'd0, 1'b1, 64'h0, "R2");
        acc(1'b0, 3'd5, 1'b0, 2'd0, 1'b0, 64'h0, "R2");
        acc(1'b0, 3'd2, 1'b1, 2'd0, 1'b1, 64'h0, "R2");
        acc(1'b0, 3'd0, 1'b1, 2'd0, 1'b0, 64'h0, "R2");

        // R3: illegal pairs
        wr(3'd0, 1'b0, 1'b1, 64'h8000_0000, "R3");
        wr(3'd0, 1'b0, 1'b1, 64'h2000_0001, "R3");
        rd(3'd0, 1'b0, "R3");
        wr(3'd0, 1'b0, 1'b1, 64'h6000_0001, "R3");

        // R4: reserved fault in FEAT and PRIO
        wr(3'd4, 1'b0, 1'b0, 64'h0000_0800, "R4");
        wr(3'd0, 1'b1, 1'b1, 64'h10, "R4");
        wr(3'd0, 1'b1, 1'b1, 64'h7, "R4");
        rd(3'd0, 1'b1, "R4");

        // R5: silent masking and forced bit 4
        wr(3'd0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFEF, "R5");
        rd(3'd0, 1'b0, "R5");
        wr(3'd3, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
        rd(3'd3, 1'b0, "R5");

        // R6 / R7 / R8: side-effect pulses
        wr(3'd0, 1'b0, 1'b1, 64'h0000_0001, "R7");
        wr(3'd3, 1'b0, 1'b1, 64'h0000_1000, "R6");
        wr(3'd4, 1'b0, 1'b0, 64'h0000_0080, "R7");
        wr(3'd0, 1'b0, 1'b1, 64'h8000_0001, "R8");
        wr(3'd4, 1'b0, 1'b1, 64'h0000_00A0, "R8");
        wr(3'd3, 1'b0, 1'b1, 64'h0000_2000, "R8");
        wr(3'd0, 1'b0, 1'b1, 64'h0000_0001, "R8");
        wr(3'd0, 1'b0, 1'b1, 64'h8000_0001, "R8");

        // R9: clearing bit 5 of FEAT in long mode
        wr(3'd4, 1'b0, 1'b1, 64'h0000_0080, "R9");
        rd(3'd4, 1'b0, "R9");
        wr(3'd4, 1'b0, 1'b0, 64'h0000_0000, "R9");

        // R10: narrow operand
        wr(3'd2, 1'b0, 1'b0, 64'hAAAA_BBBB_CCCC_DDDD, "R10");
        rd(3'd2, 1'b0, "R10");
        wr(3'd2, 1'b0, 1'b1, 64'h1111_2222_3333_4444, "R10");
        acc(1'b0, 3'd2, 1'b0, 2'd0, 1'b0, 64'h0, "R10");

        // R11: idle after a response
        @(negedge clk);
        chk(rsp_valid == 0, "R11", "idle rsp_valid", 64'(rsp_valid), 64'd0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] d;
            bit [1:0] cp;
            d = {$urandom(), $urandom()};
            case ($urandom() % 5)
                0: d = d & 64'h27FF;
                1: d = (d & MODE_KEEP) | 64'h4000_0001;
                2: d = d & 64'hFF;
                3: d = (d & 64'h27FF) | 64'h20;
                default: ;
            endcase
            cp = (($urandom() % 4) == 0) ? 2'($urandom()) : 2'd0;
            acc(1'($urandom()), 3'($urandom()), 1'($urandom()), cp, 1'($urandom()), d, "");
        end

        // Final readback of all slots
        rd(3'd0, 1'b0, "R1");
        rd(3'd2, 1'b0, "R1");
        rd(3'd3, 1'b0, "R1");
        rd(3'd4, 1'b0, "R1");
        rd(3'd0, 1'b1, "R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule